// File: doc/BRIEF.md
# Vector length configuration unit

This block executes the configuration step of a vector unit: given a requested element type and an application vector length (AVL), it decides whether the requested type is legal, works out the largest element count a register group can hold (VLMAX) and sets the active vector length to the smaller of AVL and VLMAX. The new length and type are kept in two state registers, and the new length is also returned as the scalar result of the request.

A request selects one of three operand forms. In the first, both the AVL and the type word come from scalar registers. In the second, the AVL comes from a register and the type word from an 11-bit immediate. In the third, the AVL is a 5-bit unsigned immediate and the type word is an immediate as well. The register width in bytes is a build-time parameter (32 or 64 bytes) and is presented as a constant output.

Type word layout used throughout: bits [2:0] hold the group multiplier code, bits [5:3] the element width code, bit 6 the tail policy (1 = agnostic), bit 7 the mask policy (1 = agnostic), and the top bit of the word is the illegal-type flag. Every other bit is reserved.

Top module: `vcfg_unit`

## Requirements
- R1: Multiplier codes map 0→x1, 1→x2, 2→x4, 3→x8, 5→x1/8, 6→x1/4, 7→x1/2; element width codes map 0→8, 1→16, 2→32 bits; VLMAX = register bytes × multiplier ÷ element bytes.
- R2: For a legal type, the new length is AVL when AVL ≤ VLMAX and VLMAX otherwise (so 0, 1, VLMAX−1 and VLMAX pass through and anything larger clamps).
- R3: Element width code 3 (64-bit) and codes 4 to 7 are illegal.
- R4: Multiplier code 4 is illegal, and so is any element width wider than 32 bits times the multiplier (for instance x1/8 with any width, x1/4 with 16 or 32 bits).
- R5: With an integer multiplier all four tail/mask policy settings are legal; with a fractional multiplier tail-undisturbed (bit 6 = 0) is illegal. For legal types the length does not depend on the policy bits.
- R6: Any nonzero bit outside bits [7:0] of the requested type word, including the top bit, makes the request illegal.
- R7: An illegal request stores a type word with only the top bit set, stores length 0 and returns 0.
- R8: Form code 0 takes AVL and type from the registers; code 1 takes AVL from the register and the type from the zero-extended immediate; codes 2 and 3 take the zero-extended 5-bit AVL immediate and the type immediate. Unused operands have no effect.
- R9: A request accepted with `req_valid` high updates length, type and the returned result together at the next clock edge, and the result strobe is high for exactly that one cycle. Without a request, length and type hold.
- R10: Synchronous reset sets the stored type to the illegal-flag-only word, clears the length, the result and the result strobe.
- R11: `vlenb_o` always shows the register width in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_form | input | 2 | Operand form select |
| avl_reg | input | XLEN | AVL from a scalar register |
| avl_imm | input | 5 | AVL immediate |
| vtype_reg | input | XLEN | Type word from a scalar register |
| vtype_imm | input | 11 | Type word immediate |
| vl_o | output | XLEN | Stored vector length |
| vtype_o | output | XLEN | Stored type word |
| rd_valid_o | output | 1 | Result strobe |
| rd_data_o | output | XLEN | Returned new length |
| vlenb_o | output | XLEN | Register width in bytes |

## Verification
The assertions assume only that the request inputs are stable across the sampling edge and that `req_form` is a defined two-bit value; the bench drives every input half a cycle before the edge that samples it. They take no limit on AVL or on the type word, since every type encoding, legal or not, has a defined outcome, and the bench deliberately sweeps every multiplier code, every width code, every policy pair and reserved-bit patterns. AVL stimulus sits at the VLMAX boundaries (0, 1, VLMAX−1, VLMAX, VLMAX+1) and at a large value, plus the full 5-bit immediate range.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  // positions inside the type word
  localparam int MUL_LO  = 0;
  localparam int MUL_HI  = 2;
  localparam int SEW_LO  = 3;
  localparam int SEW_HI  = 5;
  localparam int TAIL_B  = 6;
  localparam int MASK_B  = 7;
  localparam int USED_W  = 8;

  typedef enum logic [1:0] {
    FORM_REG_REG = 2'd0,
    FORM_REG_IMM = 2'd1,
    FORM_IMM_IMM = 2'd2,
    FORM_IMM_ALT = 2'd3
  } form_e;

  typedef struct packed {
    logic       mask_ag;
    logic       tail_ag;
    logic [2:0] sew;
    logic [2:0] mul;
  } vtype_lo_t;
endpackage

// File: rtl/vcfg_operand_sel.sv
module vcfg_operand_sel
  import vcfg_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int AVL_IMM_W   = 5,
  parameter int VTYPE_IMM_W = 11
) (
  input  logic [1:0]             form,
  input  logic [XLEN-1:0]        avl_reg,
  input  logic [AVL_IMM_W-1:0]   avl_imm,
  input  logic [XLEN-1:0]        vtype_reg,
  input  logic [VTYPE_IMM_W-1:0] vtype_imm,
  output logic [XLEN-1:0]        avl_sel,
  output logic [XLEN-1:0]        vtype_sel
);
  form_e f;

  always_comb begin
    f = form_e'(form);
    case (f)
      FORM_REG_REG: begin
        avl_sel   = avl_reg;
        vtype_sel = vtype_reg;
      end
      FORM_REG_IMM: begin
        avl_sel   = avl_reg;
        vtype_sel = XLEN'(vtype_imm);
      end
      default: begin
        avl_sel   = XLEN'(avl_imm);
        vtype_sel = XLEN'(vtype_imm);
      end
    endcase
  end

  // R8: immediate AVL never exceeds its field range
  always_comb begin
    if (form[1]) begin
      p_imm_avl_range_r8: assert (avl_sel < (XLEN'(1) << AVL_IMM_W))
        else $error("immediate AVL out of range");
    end
  end
endmodule

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VLENB = 32,
  parameter int VL_W  = 9
) (
  input  logic [XLEN-1:0] vtype_in,
  output logic            legal,
  output logic [VL_W-1:0] vlmax
);
  localparam int VLENB_LOG = $clog2(VLENB);

  vtype_lo_t       lo;
  logic            rsvd_set;
  logic signed [3:0] mul_log;
  logic signed [4:0] sew_lim;
  int              shamt;
  logic            frac;

  always_comb begin
    lo       = vtype_lo_t'(vtype_in[USED_W-1:0]);
    rsvd_set = |vtype_in[XLEN-1:USED_W];
    // codes 5..7 read as -3..-1 when sign-extended
    mul_log  = $signed({lo.mul[2], lo.mul});
    frac     = lo.mul[2];
    sew_lim  = 5'(mul_log) + 5'sd2;
    legal    = !rsvd_set
             && (lo.mul != 3'd4)
             && (lo.sew <= 3'd2)
             && !(frac && !lo.tail_ag)
             && ($signed({2'b00, lo.sew}) <= sew_lim);
    shamt    = VLENB_LOG + int'(mul_log) - int'(lo.sew);
    if (legal && shamt >= 0 && shamt < VL_W) begin
      vlmax = VL_W'(1) << shamt;
    end else begin
      vlmax = '0;
    end
  end

  // R1: a legal type always yields a single power-of-two VLMAX
  // R5: fractional multiplier with tail-undisturbed never passes
  always_comb begin
    if (legal) begin
      p_vlmax_pow2_r1: assert ($countones(vlmax) == 1)
        else $error("VLMAX not a power of two");
      p_frac_needs_ta_r5: assert (!(vtype_in[MUL_HI] && !vtype_in[TAIL_B]))
        else $error("fractional tail-undisturbed accepted");
      p_no_wide_sew_r3: assert (vtype_in[SEW_HI:SEW_LO] <= 3'd2)
        else $error("unsupported width accepted");
    end
  end
endmodule

// File: rtl/vcfg_clamp.sv
module vcfg_clamp #(
  parameter int XLEN = 32,
  parameter int VL_W = 9
) (
  input  logic [XLEN-1:0] avl,
  input  logic [VL_W-1:0] vlmax,
  output logic [XLEN-1:0] vl
);
  logic [XLEN-1:0] vlmax_x;

  always_comb begin
    vlmax_x = XLEN'(vlmax);
    vl      = (avl > vlmax_x) ? vlmax_x : avl;
  end

  // R2: the result never exceeds either bound
  always_comb begin
    p_vl_le_bounds_r2: assert (vl <= vlmax_x && vl <= avl)
      else $error("clamp result above a bound");
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int VLEN_BITS   = 256,
  parameter int AVL_IMM_W   = 5,
  parameter int VTYPE_IMM_W = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [1:0]             req_form,
  input  logic [XLEN-1:0]        avl_reg,
  input  logic [AVL_IMM_W-1:0]   avl_imm,
  input  logic [XLEN-1:0]        vtype_reg,
  input  logic [VTYPE_IMM_W-1:0] vtype_imm,
  output logic [XLEN-1:0]        vl_o,
  output logic [XLEN-1:0]        vtype_o,
  output logic                   rd_valid_o,
  output logic [XLEN-1:0]        rd_data_o,
  output logic [XLEN-1:0]        vlenb_o
);
  localparam int VLENB     = VLEN_BITS / 8;
  localparam int VL_W      = $clog2(VLENB) + 4;
  localparam logic [XLEN-1:0] ILL_WORD = XLEN'(1) << (XLEN - 1);
  localparam logic [XLEN-1:0] VL_CEIL  = XLEN'(VLENB * 8);

  logic [XLEN-1:0] avl_sel, vtype_sel, vl_new, vl_next, vtype_next;
  logic [VL_W-1:0] vlmax;
  logic            legal;
  logic [XLEN-1:0] vl_q, vtype_q, rd_data_q;
  logic            rd_valid_q;

  vcfg_operand_sel #(
    .XLEN(XLEN), .AVL_IMM_W(AVL_IMM_W), .VTYPE_IMM_W(VTYPE_IMM_W)
  ) sel_i (
    .form(req_form), .avl_reg(avl_reg), .avl_imm(avl_imm),
    .vtype_reg(vtype_reg), .vtype_imm(vtype_imm),
    .avl_sel(avl_sel), .vtype_sel(vtype_sel)
  );

  vcfg_decode #(.XLEN(XLEN), .VLENB(VLENB), .VL_W(VL_W)) dec_i (
    .vtype_in(vtype_sel), .legal(legal), .vlmax(vlmax)
  );

  vcfg_clamp #(.XLEN(XLEN), .VL_W(VL_W)) clamp_i (
    .avl(avl_sel), .vlmax(vlmax), .vl(vl_new)
  );

  always_comb begin
    vl_next    = legal ? vl_new : '0;
    vtype_next = legal ? vtype_sel : ILL_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q       <= '0;
      vtype_q    <= ILL_WORD;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= req_valid;
      if (req_valid) begin
        vl_q      <= vl_next;
        vtype_q   <= vtype_next;
        rd_data_q <= vl_next;
      end
    end
  end

  assign vl_o       = vl_q;
  assign vtype_o    = vtype_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign vlenb_o    = XLEN'(VLENB);

  p_ill_zero_vl_r7: assert property (@(posedge clk) disable iff (rst)
    vtype_q[XLEN-1] |-> vl_q == '0);
  p_ill_word_clean_r7: assert property (@(posedge clk) disable iff (rst)
    vtype_q[XLEN-1] |-> vtype_q[XLEN-2:0] == '0);
  p_vl_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
    vl_q <= VL_CEIL);
  p_result_is_vl_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q |-> rd_data_q == vl_q);
  p_req_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rd_valid_q);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rd_valid_q && $stable(vl_q) && $stable(vtype_q));
endmodule

// File: tb/vcfg_unit_tb_top.sv
module vcfg_unit_tb_top;
  localparam int XLEN  = 32;
  localparam int VBITS = 256;
  localparam int VLENB = VBITS / 8;
  localparam logic [31:0] ILL = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_form = 2'd0;
  logic [31:0] avl_reg = '0;
  logic [4:0]  avl_imm = '0;
  logic [31:0] vtype_reg = '0;
  logic [10:0] vtype_imm = '0;
  logic [31:0] vl_o, vtype_o, rd_data_o, vlenb_o;
  logic rd_valid_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN_BITS(VBITS)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_form(req_form),
    .avl_reg(avl_reg), .avl_imm(avl_imm), .vtype_reg(vtype_reg),
    .vtype_imm(vtype_imm), .vl_o(vl_o), .vtype_o(vtype_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .vlenb_o(vlenb_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic reference: returns VLMAX, 0 when illegal
  function automatic int model_vlmax(input logic [31:0] vt);
    int code, sew, ebytes, maxw;
    code = int'(vt[2:0]);
    sew  = int'(vt[5:3]);
    if (vt[31:8] != 0) return 0;                 // R6
    if (sew > 2 || code == 4) return 0;          // R3, R4
    if (code >= 5 && !vt[6]) return 0;           // R5
    ebytes = 1 << sew;
    if (code < 4) return (VLENB * (1 << code)) / ebytes;
    maxw = 32 / (1 << (8 - code));               // widest element bits at this fraction
    if (8 * ebytes > maxw) return 0;             // R4
    return (VLENB / (1 << (8 - code))) / ebytes;
  endfunction

  function automatic string tag_of(input logic [31:0] vt);
    if (vt[31:8] != 0) return "R6";
    if (vt[5:3] > 3'd2) return "R3";
    if (vt[2:0] == 3'd4) return "R4";
    if (vt[2] && !vt[6]) return "R5";
    if (model_vlmax(vt) == 0) return "R4";
    if (vt[7:6] != 2'b11) return "R5";
    return "R2";
  endfunction

  task automatic issue(input logic [1:0] form, input logic [31:0] ar, input logic [4:0] ai,
                       input logic [31:0] vr, input logic [10:0] vi,
                       input logic [31:0] eff_avl, input logic [31:0] eff_vt);
    int vmax;
    longint evl;
    logic [31:0] evt;
    string t;
    @(negedge clk);
    req_form = form; avl_reg = ar; avl_imm = ai; vtype_reg = vr; vtype_imm = vi;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    vmax = model_vlmax(eff_vt);
    t = tag_of(eff_vt);
    if (vmax == 0) begin
      evl = 0; evt = ILL;
      t = (t == "R2") ? "R7" : t;
    end else begin
      evl = (longint'(eff_avl) > vmax) ? vmax : longint'(eff_avl);
      evt = eff_vt;
    end
    chk(vl_o == evl, t, vl_o, evl);
    chk(vtype_o == evt, (vmax == 0) ? "R7" : "R1", vtype_o, evt);
    chk(rd_data_o == evl, "R9", rd_data_o, evl);
    chk(rd_valid_o == 1'b1, "R9", rd_valid_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(vtype_o == ILL, "R10", vtype_o, ILL);
    chk(vl_o == 0, "R10", vl_o, 0);
    chk(rd_valid_o == 0, "R10", rd_valid_o, 0);
    rst = 1'b0;
    @(negedge clk);
    // R11 constant width
    chk(vlenb_o == VLENB, "R11", vlenb_o, VLENB);

    // R1 R2 R3 R4 R5: every type field value, boundary AVLs, register form
    for (int code = 0; code < 8; code++)
      for (int sew = 0; sew < 4; sew++)
        for (int pol = 0; pol < 4; pol++) begin
          logic [31:0] vt;
          int vm;
          vt = {24'd0, 2'(pol), 3'(sew), 3'(code)};
          vm = model_vlmax(vt);
          if (vm == 0) vm = 8;
          for (int k = 0; k < 6; k++) begin
            logic [31:0] a;
            case (k)
              0: a = 0;
              1: a = 1;
              2: a = vm - 1;
              3: a = vm;
              4: a = vm + 1;
              default: a = 32'd100000;
            endcase
            issue(2'd0, a, 5'd31, vt, 11'h7ff, a, vt);
          end
        end

    // R6 reserved bits on an otherwise legal type
    issue(2'd0, 32'd5, 5'd0, 32'h0000_0100, 11'd0, 32'd5, 32'h0000_0100);
    issue(2'd0, 32'd5, 5'd0, 32'h0010_00c0, 11'd0, 32'd5, 32'h0010_00c0);
    issue(2'd0, 32'd5, 5'd0, 32'h8000_0000, 11'd0, 32'd5, 32'h8000_0000);

    // R8 register AVL with immediate type, register type ignored
    for (int code = 0; code < 4; code++)
      issue(2'd1, 32'd300, 5'd0, 32'hffff_ffff, 11'(8'hc8 | code),
            32'd300, 32'(8'hc8 | code));
    issue(2'd1, 32'd3, 5'd0, 32'd0, 11'h100, 32'd3, 32'h100);

    // R8 immediate AVL full range, register AVL ignored, both form codes
    for (int i = 0; i < 32; i++) begin
      issue(2'd2, 32'd9999, 5'(i), 32'hffff_ffff, 11'h000, 32'(i), 32'h000);
      issue(2'd3, 32'd9999, 5'(i), 32'd0, 11'h0d0, 32'(i), 32'h0d0);
      issue(2'd2, 32'd9999, 5'(i), 32'd0, 11'h0c6, 32'(i), 32'h0c6);
    end

    // R9 idle: inputs change without a request, state holds
    issue(2'd0, 32'd7, 5'd0, 32'h0000_0008, 11'd0, 32'd7, 32'h0000_0008);
    @(negedge clk);
    req_form = 2'd0; avl_reg = 32'd1; vtype_reg = 32'h0000_0003;
    @(negedge clk);
    @(negedge clk);
    chk(rd_valid_o == 0, "R9", rd_valid_o, 0);
    chk(vl_o == 7, "R9", vl_o, 7);
    chk(vtype_o == 32'h8, "R9", vtype_o, 32'h8);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule